// File: doc/BRIEF.md
# Serial Display Register Access Engine

This block is a three-wire serial master that a host uses to program the indexed registers of a display controller and to read back its 16-bit identification code. The host presents an operation (write or read), a register index, a 16-bit value and a one-cycle start strobe. It then waits for a one-cycle done pulse. For a read, the captured code appears on the read-data output with that pulse.

On the pin side the block drives an active-low chip-select, a serial clock and a data-out line, and it samples a data-in line. Every exchange is made of two frames, and chip-select is raised between them. The first frame always carries the register index behind a fixed prefix. A write follows it with a value frame. A read follows it with a long frame: that frame sends a short read code and then keeps clocking, and it keeps only the last sixteen bits that come back. All serial timing comes from a divider that sets how many system clocks each half of the serial clock lasts.

Top module: `lcd_reg_link`

## Requirements
- R1: After reset and whenever no exchange is running, `cs_n` and `sclk` are high, and `busy` and `done` are low.
- R2: A write (`op`=0) sends two 24-bit frames. The first is 0x70 in bits 23:16, zero in bits 15:8 and `idx` in bits 7:0. The second is 0x72 in bits 23:16 and `value` in bits 15:0.
- R3: Each frame lies within one low period of `cs_n`. `cs_n` goes high between the two frames, so one operation gives exactly two low periods.
- R4: Frame bits go out most significant first, one bit per `sclk` rising edge. `mosi` changes only while `sclk` is low.
- R5: A read (`op`=1) sends the 24-bit frame 0x700000 and then a frame of 40 clocks. The first 16 bits of that frame are 0x7300 and the remaining 24 bits are driven low.
- R6: In the read's second frame, `miso` is sampled at each `sclk` rising edge. Only clocks 24 to 39 (counted from 0) are kept, shifted in MSB first, so clock 24 gives bit 15 of `rd_data`.
- R7: Each high and each low level of `sclk` inside a frame lasts `DIV` system clocks. The time from the fall of `cs_n` to the first fall of `sclk` is at least `DIV` clocks, and so is the time from the last rise of `sclk` to the rise of `cs_n`.
- R8: `busy` is high from the cycle after an accepted start until the final frame ends. `done` is a single-cycle pulse, and `busy` is low while `done` is high.
- R9: A start strobe that arrives while `busy` is high is ignored. The running operation's frames, and their number, are unchanged.
- R10: `rd_data` changes only together with the `done` pulse that ends a read. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 1 | 0 = register write, 1 = identification read |
| idx | input | IDX_W | Register index for a write |
| value | input | DATA_W | Value for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Code captured by the last read |
| cs_n | output | 1 | Active-low chip-select |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is the read reply window. The engine must throw away 24 clocks of `miso` and then keep the next 16 in the correct order. To exercise this, the bench slave drives random junk on every clock before clock 24 and a random reply after it, changing `miso` on each falling edge of `sclk`. A wrong skip count or a wrong bit order then shows up directly in `rd_data`. Some operations also get a second start strobe with a different operation in the middle of the first frame. The bench then decodes the frames from the pins and checks that nothing changed.

// File: rtl/lrl_pkg.sv
// Shared definitions for the serial display register engine.
// Assumes an 8-bit frame prefix and a 16-bit read code.
package lrl_pkg;
    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;

    localparam logic [7:0]  PFX_INDEX = 8'h70;
    localparam logic [7:0]  PFX_VALUE = 8'h72;
    localparam logic [15:0] READ_CODE = 16'h7300;
    localparam int          READ_CODE_W = 16;
endpackage

// File: rtl/lrl_tick.sv
// Half-period timer: while run is high it emits one tick every DIV cycles.
// The first tick comes DIV cycles after run rises. Assumes DIV >= 1.
module lrl_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count system clocks inside a half-period; restart while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/lrl_shifter.sv
// Frame shifter: runs one chip-select frame of n_clk serial clocks.
// The first n_out bits of word go out MSB first and data-out is low after them.
// miso is captured on clocks numbered skip and above.
// A frame is: setup, n_clk low/high pairs, hold, gap. Each step lasts one tick.
// Assumes go is only pulsed while the shifter is idle.
module lrl_shifter #(
    parameter int FRAME_W = 24,
    parameter int CAP_W   = 16,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] word,
    input  logic [CNT_W-1:0]   n_out,
    input  logic [CNT_W-1:0]   n_clk,
    input  logic [CNT_W-1:0]   skip,
    input  logic               tick,
    input  logic               miso,
    output logic               run,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    output logic [CAP_W-1:0]   cap,
    output logic               frame_done
);
    typedef enum logic [2:0] {
        F_IDLE, F_SETUP, F_LOW, F_HIGH, F_HOLD, F_GAP
    } fstate_e;

    fstate_e            st;
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   bitn;
    logic [CNT_W-1:0]   nout_q;
    logic [CNT_W-1:0]   nclk_q;
    logic [CNT_W-1:0]   skip_q;
    logic               next_bit;

    // Bit placed on data-out at the next low phase.
    assign next_bit = (bitn < nout_q) ? sh[FRAME_W-1] : 1'b0;
    assign run = (st != F_IDLE);

    // Frame sequencing, pin drive and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= F_IDLE;
            sh         <= '0;
            bitn       <= '0;
            nout_q     <= '0;
            nclk_q     <= '0;
            skip_q     <= '0;
            cs_n       <= 1'b1;
            sclk       <= 1'b1;
            mosi       <= 1'b0;
            cap        <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (st)
                F_IDLE: begin
                    if (go) begin
                        st     <= F_SETUP;
                        sh     <= word;
                        nout_q <= n_out;
                        nclk_q <= n_clk;
                        skip_q <= skip;
                        bitn   <= '0;
                        cap    <= '0;
                        cs_n   <= 1'b0;
                    end
                end
                F_SETUP: begin
                    if (tick) begin
                        st   <= F_LOW;
                        sclk <= 1'b0;
                        mosi <= next_bit;
                        sh   <= sh << 1;
                    end
                end
                F_LOW: begin
                    if (tick) begin
                        st   <= F_HIGH;
                        sclk <= 1'b1;
                        if (bitn >= skip_q)
                            cap <= {cap[CAP_W-2:0], miso};
                    end
                end
                F_HIGH: begin
                    if (tick) begin
                        if (bitn == nclk_q - 1'b1) begin
                            st <= F_HOLD;
                        end else begin
                            st   <= F_LOW;
                            bitn <= bitn + 1'b1;
                            sclk <= 1'b0;
                            mosi <= ((bitn + 1'b1) < nout_q) ? sh[FRAME_W-1] : 1'b0;
                            sh   <= sh << 1;
                        end
                    end
                end
                F_HOLD: begin
                    if (tick) begin
                        st   <= F_GAP;
                        cs_n <= 1'b1;
                    end
                end
                F_GAP: begin
                    if (tick) begin
                        st         <= F_IDLE;
                        frame_done <= 1'b1;
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R4
    mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !sclk);

    // R3
    done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> cs_n);
endmodule

// File: rtl/lrl_seq.sv
// Operation sequencer: on an accepted start it runs the index frame and then
// the value frame (write) or the long reply frame (read). It reports done and
// latches the read result. Assumes FRAME_W = 8 + DATA_W.
module lrl_seq #(
    parameter int IDX_W     = 8,
    parameter int DATA_W    = 16,
    parameter int FRAME_W   = 24,
    parameter int READ_CLKS = 40,
    parameter int CNT_W     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               op,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  value,
    input  logic               frame_done,
    input  logic [DATA_W-1:0]  cap,
    output logic               go,
    output logic [FRAME_W-1:0] word,
    output logic [CNT_W-1:0]   n_out,
    output logic [CNT_W-1:0]   n_clk,
    output logic [CNT_W-1:0]   skip,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data
);
    import lrl_pkg::*;

    localparam int PAD_W = FRAME_W - 8;
    localparam logic [CNT_W-1:0] FW_C   = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] RD_C   = CNT_W'(READ_CLKS);
    localparam logic [CNT_W-1:0] CODE_C = CNT_W'(READ_CODE_W);

    typedef enum logic [1:0] { Q_IDLE, Q_IDX, Q_TAIL } qstate_e;

    qstate_e           st;
    op_e               op_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] val_q;

    assign busy = (st != Q_IDLE);

    // Frame contents and lengths for the current step.
    always_comb begin
        word  = {PFX_INDEX, PAD_W'(idx_q)};
        n_out = FW_C;
        n_clk = FW_C;
        skip  = FW_C;
        if (st == Q_IDX && op_q == OP_READ) begin
            word = {PFX_INDEX, {PAD_W{1'b0}}};
        end else if (st == Q_TAIL && op_q == OP_WRITE) begin
            word = {PFX_VALUE, val_q};
        end else if (st == Q_TAIL) begin
            word  = {READ_CODE, {(FRAME_W-READ_CODE_W){1'b0}}};
            n_out = CODE_C;
            n_clk = RD_C;
            skip  = FW_C;
        end
    end

    // Accept requests, chain the two frames, report completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= Q_IDLE;
            op_q    <= OP_WRITE;
            idx_q   <= '0;
            val_q   <= '0;
            go      <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            case (st)
                Q_IDLE: begin
                    if (start) begin
                        st    <= Q_IDX;
                        op_q  <= op_e'(op);
                        idx_q <= idx;
                        val_q <= value;
                        go    <= 1'b1;
                    end
                end
                Q_IDX: begin
                    if (frame_done) begin
                        st <= Q_TAIL;
                        go <= 1'b1;
                    end
                end
                Q_TAIL: begin
                    if (frame_done) begin
                        st   <= Q_IDLE;
                        done <= 1'b1;
                        if (op_q == OP_READ)
                            rd_data <= cap;
                    end
                end
                default: st <= Q_IDLE;
            endcase
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(op_q) && $stable(idx_q) && $stable(val_q)));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> (done && op_q == OP_READ));
endmodule

// File: rtl/lcd_reg_link.sv
// Top of the serial display register engine. It connects the sequencer,
// the frame shifter and the half-period timer.
// Assumes a synchronous miso and DIV >= 1.
module lcd_reg_link #(
    parameter int DIV       = 2,
    parameter int IDX_W     = 8,
    parameter int DATA_W    = 16,
    parameter int READ_CLKS = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] value,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int FRAME_W = 8 + DATA_W;
    localparam int CNT_W   = $clog2(READ_CLKS + 1);

    logic               go;
    logic [FRAME_W-1:0] word;
    logic [CNT_W-1:0]   n_out;
    logic [CNT_W-1:0]   n_clk;
    logic [CNT_W-1:0]   skip;
    logic               run;
    logic               tick;
    logic               frame_done;
    logic [DATA_W-1:0]  cap;

    lrl_seq #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W),
        .READ_CLKS(READ_CLKS), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .idx(idx),
        .value(value), .frame_done(frame_done), .cap(cap), .go(go),
        .word(word), .n_out(n_out), .n_clk(n_clk), .skip(skip),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    lrl_shifter #(
        .FRAME_W(FRAME_W), .CAP_W(DATA_W), .CNT_W(CNT_W)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .go(go), .word(word), .n_out(n_out),
        .n_clk(n_clk), .skip(skip), .tick(tick), .miso(miso), .run(run),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .cap(cap),
        .frame_done(frame_done)
    );

    lrl_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    // R8
    busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
endmodule

// File: tb/sim_lcd_reg_link.sv
module sim_lcd_reg_link;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op = 1'b0;
    logic [7:0]  idx = '0;
    logic [15:0] value = '0;
    logic        busy, done, cs_n, sclk, mosi;
    logic        miso = 1'b0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;

    // slave monitor state
    logic        p_cs = 1'b1, p_sclk = 1'b1, p_mosi = 1'b0;
    logic [39:0] cur_w;
    int          cur_b, falls, since_cs, since_edge;
    logic [39:0] fw [0:3];
    int          fb [0:3];
    int          nfr;
    int          bad_half, bad_setup, bad_hold, bad_mosi;
    logic [15:0] reply;
    logic [15:0] exp_rd = '0;

    lcd_reg_link #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .idx(idx),
        .value(value), .busy(busy), .done(done), .rd_data(rd_data),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] idx_frame(input logic [7:0] i);
        return {8'h70, 8'h00, i};
    endfunction

    function automatic logic [23:0] val_frame(input logic [15:0] v);
        return {8'h72, v};
    endfunction

    // Pin-level slave: decode frames, measure timing, drive the reply.
    always @(negedge clk) begin
        since_cs++;
        since_edge++;
        if (p_cs && !cs_n) begin
            cur_w = '0; cur_b = 0; falls = 0; since_cs = 0;
        end
        if (!cs_n && p_sclk && !sclk) begin
            if (falls == 0) begin
                if (since_cs < DIV) bad_setup++;
            end else if (since_edge != DIV) bad_half++;
            if (falls >= 24 && falls < 40) miso <= reply[15 - (falls - 24)];
            else miso <= 1'($urandom);
            falls++;
            since_edge = 0;
        end
        if (!cs_n && !p_sclk && sclk) begin
            if (since_edge != DIV) bad_half++;
            cur_w = {cur_w[38:0], mosi};
            cur_b++;
            since_edge = 0;
        end
        if (!cs_n && sclk && p_sclk && (mosi != p_mosi)) bad_mosi++;
        if (!p_cs && cs_n) begin
            if (since_edge < DIV) bad_hold++;
            if (nfr < 4) begin fw[nfr] = cur_w; fb[nfr] = cur_b; end
            nfr++;
        end
        p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
    end

    task automatic run_op(input logic o, input logic [7:0] i, input logic [15:0] v,
                          input logic [15:0] rep, input bit spurious);
        bit got;
        nfr = 0; bad_half = 0; bad_setup = 0; bad_hold = 0; bad_mosi = 0;
        reply = rep;
        @(negedge clk);
        op = o; idx = i; value = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy after start", 64'(busy), 64'd1);
        if (spurious) begin
            repeat (20) @(negedge clk);
            op = ~o; idx = ~i; value = ~v; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        got = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (done) begin got = 1; break; end
        end
        chk(got, "R8 done watchdog", 64'(got), 64'd1);
        chk(busy == 1'b0, "R8 busy low at done", 64'(busy), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", 64'(done), 64'd0);
        chk(cs_n && sclk, "R1 idle pins", 64'({cs_n, sclk}), 64'h3);
        chk(nfr == 2, spurious ? "R9 frame count with extra start" : "R3 frame count",
            64'(nfr), 64'd2);
        chk(bad_half == 0, "R7 half period", 64'(bad_half), 64'd0);
        chk(bad_setup == 0 && bad_hold == 0, "R7 cs setup/hold",
            64'({bad_setup[15:0], bad_hold[15:0]}), 64'd0);
        chk(bad_mosi == 0, "R4 mosi stable while sclk high", 64'(bad_mosi), 64'd0);
        if (o == 1'b0) begin
            chk(fb[0] == 24 && fw[0][23:0] == idx_frame(i), "R2 index frame",
                64'(fw[0]), 64'(idx_frame(i)));
            chk(fb[1] == 24 && fw[1][23:0] == val_frame(v), "R2 value frame",
                64'(fw[1]), 64'(val_frame(v)));
            chk(rd_data == exp_rd, "R10 rd_data kept over write", 64'(rd_data),
                64'(exp_rd));
        end else begin
            chk(fb[0] == 24 && fw[0][23:0] == 24'h700000, "R5 read index frame",
                64'(fw[0]), 64'h700000);
            chk(fb[1] == 40 && fw[1] == {16'h7300, 24'h0}, "R5 read code frame",
                64'(fw[1]), 64'({16'h7300, 24'h0}));
            exp_rd = rep;
            chk(rd_data == rep, "R6 captured reply", 64'(rd_data), 64'(rep));
        end
        if (spurious)
            chk(o ? (fw[1][39:24] == 16'h7300) : (fw[0][7:0] == i),
                "R9 extra start ignored", 64'(fw[0]), 64'(idx_frame(i)));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && sclk, "R1 reset pins", 64'({cs_n, sclk}), 64'h3);
        chk(!busy && !done, "R1 reset busy/done", 64'({busy, done}), 64'h0);
        chk(rd_data == 16'h0, "R10 reset rd_data", 64'(rd_data), 64'h0);
        // directed corners
        run_op(1'b0, 8'h00, 16'h0000, 16'h0, 0);
        run_op(1'b0, 8'hFF, 16'hFFFF, 16'h0, 0);
        run_op(1'b1, 8'h00, 16'h0000, 16'h8001, 0);
        run_op(1'b1, 8'h00, 16'h0000, 16'h0154, 1);
        run_op(1'b0, 8'h92, 16'h0010, 16'h0, 1);
        // random mix
        for (int n = 0; n < 14; n++)
            run_op(1'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
                   1'(($urandom % 4) == 0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule